// File: doc/BRIEF.md
# Serial EEPROM Word Access Controller

This block is the host-side master for a byte-addressed serial EEPROM on a four-wire serial bus. The bus runs in clock mode 0: the clock idles low, the device samples on the rising edge, and data changes on the falling edge. Chip select is active low. The host issues one request with a word offset, a word count and a direction. For a write, the host supplies 16-bit words through a take strobe. For a read, the words return through a valid strobe. The block pulses `done_o` when the request ends and pulses `error_o` with it if the device never reported ready.

Every device burst starts with a status poll. The status opcode is shifted out and eight status bits are shifted in. Bit 0 set means the device is still busy. A short deselect pulse separates polls and separates commands, and the number of polls is bounded. A read sends one opcode and one byte address, then clocks data continuously while the device auto-increments. A write sends write-enable, a deselect pulse, then the write opcode and address, then data words. The burst stops at every page boundary of the device, and the block restarts with a fresh poll and write-enable. On parts with 8-bit addressing, the ninth byte-address bit travels inside the opcode.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the data output is high, and `busy_o`, `done_o`, `error_o`, `rdata_valid_o` and `wdata_take_o` are low.
- R2: Every burst begins with status polls. Each poll is opcode 0x05 followed by 8 bits read back, and a chip-select pulse separates it from the next poll or command. Polling repeats while bit 0 of the status is 1 and stops at the first poll with bit 0 equal to 0.
- R3: If MAX_POLLS consecutive polls all report busy, the request ends with `done_o` and `error_o` together, and no read or write command is issued.
- R4: The address field is the word offset times two. It is sent as ADDR_BITS bits, MSB first, directly after the command opcode.
- R5: With ADDR_BITS = 8, a word offset of 128 or above ORs 0x08 into the read opcode (0x03) or write opcode (0x02). Below 128 the opcode is sent as it is.
- R6: A read of N words uses one opcode and one address, then clocks 16·N bits without deselecting, and pulses `rdata_valid_o` once per word. A read past the last word continues from word 0.
- R7: Host word bits [7:0] sit at byte address 2·offset and bits [15:8] at 2·offset+1. On the wire, the low byte is sent or received first, in both directions.
- R8: Each write burst is opcode 0x06, then a chip-select pulse, then opcode 0x02 with the address, then data words.
- R9: When the byte address after a written word is a multiple of PAGE_BYTES, the burst ends. The remaining words restart with a new poll, write-enable and write command.
- R10: Data output changes only while the serial clock is low. The clock is low whenever chip select is high, and the data output is high whenever chip select is high.
- R11: Each high phase and each low phase of the serial clock inside a field lasts `clk_div_i` clock cycles. A value of 0 acts as 1.
- R12: A request with a word count of 0 gives `done_o` on the next cycle with no bus activity.
- R13: A write pulses `wdata_take_o` once per word. `wdata_i` is sampled in the cycle of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | DIV_W | Serial half-period in clock cycles |
| req_valid_i | input | 1 | Start a request (taken while not busy) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | ADDR_BITS | First word offset |
| req_count_i | input | ADDR_BITS+1 | Number of words |
| wdata_i | input | 16 | Write word presented by the host |
| wdata_take_o | output | 1 | Write word consumed this cycle |
| rdata_o | output | 16 | Read word |
| rdata_valid_o | output | 1 | Read word valid |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| error_o | output | 1 | Device never ready (with done_o) |
| spi_sck_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to device |
| spi_miso_i | input | 1 | Serial data from device |

## Verification
The bench targets page-crossing writes. A design that ignored the page rule would let the device wrap inside the page and overwrite earlier words. It also targets offsets above 127, where a missing extra-address bit puts data in the lower half of memory. A read that crosses the top of memory must continue from word 0. A device held busy for the whole poll limit must end in an error with no command issued, and a too-small limit or a wrong busy-bit test would either hang or issue the command early. Reversed byte order is caught by comparing the device's byte array with the host words. Clock-phase errors are caught by watching the data line while the clock is high and by measuring clock high phases under two divider settings.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam int unsigned LEN_W = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL_OP,
    ST_POLL_IN,
    ST_POLL_GAP,
    ST_WREN,
    ST_WREN_GAP,
    ST_CMD,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_PAGE_GAP
  } ctrl_state_e;

  function automatic logic [15:0] swap16(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

endpackage

// File: rtl/spi_eeprom_tick.sv
module spi_eeprom_tick #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_eeprom_shifter.sv
module spi_eeprom_shifter
  import spi_eeprom_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [15:0]      data_i,
  input  logic             tick_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [15:0]      rx_o
);

  logic             busy_q, sck_q, done_q;
  logic [15:0]      tx_q, rx_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '1;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        tx_q   <= data_i << (LEN_W'(16) - len_i);  // left-align field
        rx_q   <= '0;
        cnt_q  <= len_i;
      end else if (busy_q && tick_i) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[14:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          tx_q  <= {tx_q[14:0], 1'b1};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = busy_q ? tx_q[15] : 1'b1;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  AST_SCK_ONLY_IN_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> busy_q) else $error("sck high outside a field");  // R10
  AST_MOSI_STABLE_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(mosi_o)) else $error("mosi moved with sck high");  // R10
  AST_FIELD_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0)) else $error("empty field in flight");  // R11

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_BITS  = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned MAX_POLLS  = 8,
  parameter int unsigned DIV_W      = 4,
  parameter logic [7:0]  OP_READ    = 8'h03,
  parameter logic [7:0]  OP_WRITE   = 8'h02,
  parameter logic [7:0]  OP_WREN    = 8'h06,
  parameter logic [7:0]  OP_RDSR    = 8'h05,
  parameter logic [7:0]  OP_A8      = 8'h08
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_W-1:0]     clk_div_i,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [ADDR_BITS-1:0] req_offset_i,
  input  logic [ADDR_BITS:0]   req_count_i,
  input  logic [15:0]          wdata_i,
  output logic                 wdata_take_o,
  output logic [15:0]          rdata_o,
  output logic                 rdata_valid_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 error_o,
  output logic                 spi_sck_o,
  output logic                 spi_cs_no,
  output logic                 spi_mosi_o,
  input  logic                 spi_miso_i
);

  localparam int unsigned OFF_W    = ADDR_BITS;
  localparam int unsigned CNT_W    = OFF_W + 1;
  localparam int unsigned WPP_BITS = $clog2(PAGE_BYTES) - 1;
  localparam int unsigned POLL_W   = $clog2(MAX_POLLS + 1);
  localparam bit          USE_A8   = (ADDR_BITS == 8);

  ctrl_state_e       state_q;
  logic              armed_q, is_wr_q, dev_busy_q;
  logic [OFF_W-1:0]  cur_q, cur_nxt;
  logic [CNT_W-1:0]  rem_q;
  logic [POLL_W-1:0] poll_q;
  logic [15:0]       rdata_q;
  logic              rvalid_q, done_q, err_q;

  logic              sh_start, sh_done, sh_busy, gap_arm, tick;
  logic [LEN_W-1:0]  sh_len;
  logic [15:0]       sh_data, sh_rx, addr16;
  logic [7:0]        cmd_op;
  logic              a8, page_end, in_gap;

  assign cur_nxt  = cur_q + 1'b1;
  assign page_end = (cur_nxt[WPP_BITS-1:0] == '0);
  assign a8       = USE_A8 && cur_q[OFF_W-1];
  assign cmd_op   = (is_wr_q ? OP_WRITE : OP_READ) | (a8 ? OP_A8 : 8'h00);
  assign addr16   = 16'({cur_q, 1'b0});
  assign in_gap   = (state_q == ST_POLL_GAP) || (state_q == ST_WREN_GAP) ||
                    (state_q == ST_PAGE_GAP);

  always_comb begin
    sh_start = 1'b0;
    gap_arm  = 1'b0;
    sh_len   = LEN_W'(8);
    sh_data  = 16'h0000;
    unique case (state_q)
      ST_POLL_OP: begin sh_data = {8'h00, OP_RDSR}; sh_start = !armed_q; end
      ST_POLL_IN: sh_start = !armed_q;
      ST_WREN:    begin sh_data = {8'h00, OP_WREN}; sh_start = !armed_q; end
      ST_CMD:     begin sh_data = {8'h00, cmd_op};  sh_start = !armed_q; end
      ST_ADDR:    begin sh_len = LEN_W'(ADDR_BITS); sh_data = addr16; sh_start = !armed_q; end
      ST_RD:      begin sh_len = LEN_W'(16); sh_start = !armed_q; end
      ST_WR:      begin sh_len = LEN_W'(16); sh_data = swap16(wdata_i); sh_start = !armed_q; end
      ST_POLL_GAP, ST_WREN_GAP, ST_PAGE_GAP: gap_arm = !armed_q;
      default: ;
    endcase
  end

  spi_eeprom_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sh_start | gap_arm),
    .div_i   (clk_div_i),
    .tick_o  (tick)
  );

  spi_eeprom_shifter i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .len_i   (sh_len),
    .data_i  (sh_data),
    .tick_i  (tick),
    .miso_i  (spi_miso_i),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      armed_q    <= 1'b0;
      is_wr_q    <= 1'b0;
      dev_busy_q <= 1'b0;
      cur_q      <= '0;
      rem_q      <= '0;
      poll_q     <= '0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rvalid_q <= 1'b0;
      if (sh_start || gap_arm) armed_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (req_count_i == '0) begin
            done_q <= 1'b1;
          end else begin
            is_wr_q <= req_write_i;
            cur_q   <= req_offset_i;
            rem_q   <= req_count_i;
            poll_q  <= '0;
            armed_q <= 1'b0;
            state_q <= ST_POLL_OP;
          end
        end
        ST_POLL_OP: if (armed_q && sh_done) begin
          armed_q <= 1'b0;
          state_q <= ST_POLL_IN;
        end
        ST_POLL_IN: if (armed_q && sh_done) begin
          armed_q    <= 1'b0;
          dev_busy_q <= sh_rx[0];
          state_q    <= ST_POLL_GAP;
        end
        ST_POLL_GAP: if (armed_q && tick) begin
          armed_q <= 1'b0;
          if (!dev_busy_q) begin
            state_q <= is_wr_q ? ST_WREN : ST_CMD;
          end else if (poll_q == POLL_W'(MAX_POLLS - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            poll_q  <= poll_q + 1'b1;
            state_q <= ST_POLL_OP;
          end
        end
        ST_WREN: if (armed_q && sh_done) begin
          armed_q <= 1'b0;
          state_q <= ST_WREN_GAP;
        end
        ST_WREN_GAP: if (armed_q && tick) begin
          armed_q <= 1'b0;
          state_q <= ST_CMD;
        end
        ST_CMD: if (armed_q && sh_done) begin
          armed_q <= 1'b0;
          state_q <= ST_ADDR;
        end
        ST_ADDR: if (armed_q && sh_done) begin
          armed_q <= 1'b0;
          state_q <= is_wr_q ? ST_WR : ST_RD;
        end
        ST_RD: if (armed_q && sh_done) begin
          armed_q  <= 1'b0;
          rdata_q  <= swap16(sh_rx);
          rvalid_q <= 1'b1;
          rem_q    <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_WR: if (armed_q && sh_done) begin
          armed_q <= 1'b0;
          cur_q   <= cur_nxt;
          rem_q   <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (page_end) begin
            state_q <= ST_PAGE_GAP;
          end
        end
        ST_PAGE_GAP: if (armed_q && tick) begin
          armed_q <= 1'b0;
          poll_q  <= '0;
          state_q <= ST_POLL_OP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_no     = (state_q == ST_IDLE) || in_gap;
  assign wdata_take_o  = (state_q == ST_WR) && !armed_q;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign error_o       = err_q;

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o) else $error("sck high while deselected");  // R10
  AST_MOSI_HIGH_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> spi_mosi_o) else $error("mosi low while deselected");  // R10
  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < POLL_W'(MAX_POLLS)) else $error("poll count past limit");  // R3
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o) else $error("error without done");  // R3
  AST_TAKE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_take_o |-> (is_wr_q && !sh_busy)) else $error("take outside write");  // R13
  AST_RVALID_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> !is_wr_q) else $error("read data during write");  // R6

endmodule

// File: tb/test_spi_eeprom_ctrl.sv
module test_spi_eeprom_ctrl;
  localparam int ADDR_BITS  = 8;
  localparam int PAGE_BYTES = 16;
  localparam int MAX_POLLS  = 8;
  localparam int DIV_W      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [DIV_W-1:0]     clk_div;
  logic                 req_valid, req_write;
  logic [ADDR_BITS-1:0] req_offset;
  logic [ADDR_BITS:0]   req_count;
  logic [15:0]          wdata, rdata;
  logic                 take, rvalid, busy, done, err;
  logic                 sck, cs_n, mosi;
  logic                 miso = 1'b1;

  logic [15:0] wr_buf [0:255];
  logic [15:0] rd_buf [0:255];
  logic [15:0] shadow [0:255];
  int wr_idx = 0;
  assign wdata = wr_buf[wr_idx[7:0]];

  spi_eeprom_ctrl #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES),
                    .MAX_POLLS(MAX_POLLS), .DIV_W(DIV_W)) i_spi_eeprom_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(clk_div),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_offset_i(req_offset), .req_count_i(req_count),
    .wdata_i(wdata), .wdata_take_o(take),
    .rdata_o(rdata), .rdata_valid_o(rvalid),
    .busy_o(busy), .done_o(done), .error_o(err),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // ---------------- device model ----------------
  logic [7:0] mem [0:511];
  logic [7:0] op, sh_in, sh_out;
  logic [8:0] maddr;
  logic       wel = 1'b0, wrote = 1'b0, last_a8 = 1'b0;
  int bits = 0, busy_left = 0, busy_after_write = 0;
  int n_status = 0, n_wren = 0, n_rd = 0, n_wr = 0, n_cs = 0;

  always @(negedge cs_n) begin
    bits = 0; op = 8'h00; wrote = 1'b0; n_cs++;
  end

  always @(posedge cs_n) begin
    if (wrote) begin
      wel = 1'b0;
      busy_left = busy_after_write;
    end
    wrote = 1'b0;
  end

  always @(posedge sck) if (!cs_n) begin
    sh_in = {sh_in[6:0], mosi};
    bits++;
    if (bits % 8 == 0) begin
      if (bits == 8) begin
        op = sh_in;
        case (op & 8'hF7)
          8'h05: begin
            n_status++;
            sh_out = (busy_left > 0) ? 8'h01 : 8'h00;
            if (busy_left > 0) busy_left--;
          end
          8'h06: begin wel = 1'b1; n_wren++; end
          8'h03: begin n_rd++; last_a8 = op[3]; end
          8'h02: begin n_wr++; last_a8 = op[3]; end
          default: ;
        endcase
      end else if (bits == 16 && ((op & 8'hF7) == 8'h03 || (op & 8'hF7) == 8'h02)) begin
        maddr = {op[3], sh_in};
        if ((op & 8'hF7) == 8'h03) begin
          sh_out = mem[maddr]; maddr = maddr + 9'd1;
        end
      end else if (bits > 16 && (op & 8'hF7) == 8'h03) begin
        sh_out = mem[maddr]; maddr = maddr + 9'd1;
      end else if (bits > 16 && (op & 8'hF7) == 8'h02) begin
        if (wel) begin mem[maddr] = sh_in; wrote = 1'b1; end
        maddr = {maddr[8:4], maddr[3:0] + 4'd1};  // device wraps inside its page
      end
    end
  end

  always @(negedge sck) if (!cs_n) begin
    miso = sh_out[7];
    sh_out = {sh_out[6:0], 1'b1};
  end

  // ---------------- monitors ----------------
  int hi_run = 0, last_hi = 0, phase_viol = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b1;
  always @(negedge clk) begin
    if (sck) hi_run++;
    else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
    if (prev_sck && sck && (mosi !== prev_mosi)) phase_viol++;
    prev_sck = sck; prev_mosi = mosi;
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 16'h0123) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] dev_word(input int w);
    return {mem[2*w+1], mem[2*w]};
  endfunction

  bit op_err;
  int op_rd_n, op_take;

  task automatic run_op(input bit wr, input int off, input int cnt);
    bit pend = 1'b0;
    wr_idx = 0; op_rd_n = 0; op_take = 0; op_err = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_offset = ADDR_BITS'(off); req_count = (ADDR_BITS+1)'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (pend) begin wr_idx++; pend = 1'b0; end
      if (take) begin pend = 1'b1; op_take++; end
      if (rvalid) begin rd_buf[op_rd_n[7:0]] = rdata; op_rd_n++; end
      if (done) begin op_err = err; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_write(input int off, input int cnt);
    run_op(1'b1, off, cnt);
    for (int i = 0; i < cnt; i++) shadow[(off + i) % 256] = wr_buf[i];
  endtask

  task automatic read_cmp(input string req, input int off, input int cnt);
    run_op(1'b0, off, cnt);
    check({req, " read count"}, op_rd_n, cnt);
    for (int i = 0; i < cnt; i++) check({req, " read word"}, rd_buf[i], shadow[(off + i) % 256]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s0, s1, s2, s3, s4;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 256; i++) begin
      shadow[i] = init_word(i);
      mem[2*i] = shadow[i][7:0];
      mem[2*i+1] = shadow[i][15:8];
    end
    clk_div = 4'd2; req_valid = 1'b0; req_write = 1'b0;
    req_offset = '0; req_count = '0;
    repeat (3) @(negedge clk);
    check("R1 reset pins", {cs_n, sck, mosi, busy, done, err, rvalid, take}, 8'b10100000);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: zero-length request
    s0 = n_cs;
    run_op(1'b0, 5, 0);
    check("R12 done without bus", n_cs - s0, 0);

    // R8 / R13 / R7: single-page write
    for (int i = 0; i < 4; i++) wr_buf[i] = 16'hA100 + 16'(i * 16'h0111);
    s0 = n_wren; s1 = n_wr;
    do_write(3, 4);
    check("R13 take count", op_take, 4);
    check("R8 write enable count", n_wren - s0, 1);
    check("R8 write cmd count", n_wr - s1, 1);
    check("R7 low byte first", mem[6], 8'h00);
    check("R7 high byte second", mem[7], 8'hA1);
    check("R8 no error", op_err, 0);
    read_cmp("R6", 3, 4);

    // R9: crosses a page boundary after word 7
    for (int i = 0; i < 5; i++) wr_buf[i] = 16'hB000 + 16'(i);
    s0 = n_wren; s1 = n_wr; s2 = n_status;
    do_write(6, 5);
    check("R9 write enables", n_wren - s0, 2);
    check("R9 write bursts", n_wr - s1, 2);
    check("R9 polls per burst", n_status - s2, 2);
    for (int i = 6; i < 11; i++) check("R9 device word", dev_word(i), shadow[i]);

    // R5 / R4: upper half of an 8-bit part
    wr_buf[0] = 16'hC0DE; wr_buf[1] = 16'hF00D;
    do_write(200, 2);
    check("R5 extra bit set", last_a8, 1);
    check("R4 byte address", {mem[401], mem[400]}, 16'hC0DE);
    check("R4 next word", dev_word(201), 16'hF00D);
    read_cmp("R5", 200, 2);
    check("R5 read extra bit", last_a8, 1);
    wr_buf[0] = 16'h1234;
    do_write(100, 1);
    check("R5 extra bit clear", last_a8, 0);
    check("R4 low offset", dev_word(100), 16'h1234);

    // R2: device busy for three polls after a write
    busy_after_write = 3;
    wr_buf[0] = 16'h7E57;
    do_write(20, 1);
    busy_after_write = 0;
    s0 = n_status; s1 = n_rd;
    read_cmp("R2", 20, 1);
    check("R2 poll count", n_status - s0, 4);
    check("R2 single command", n_rd - s1, 1);

    // R3: device never ready
    busy_left = MAX_POLLS + 5;
    s0 = n_status; s1 = n_rd;
    run_op(1'b0, 40, 3);
    check("R3 error flag", op_err, 1);
    check("R3 poll limit", n_status - s0, MAX_POLLS);
    check("R3 no command", n_rd - s1, 0);
    check("R3 no data", op_rd_n, 0);
    busy_left = 0;

    // R6: read wraps past the top word
    s1 = n_rd;
    read_cmp("R6 wrap", 254, 4);
    check("R6 one command", n_rd - s1, 1);

    // R11: divider settings
    clk_div = 4'd5;
    read_cmp("R11", 10, 1);
    check("R11 half period 5", last_hi, 5);
    clk_div = 4'd0;
    read_cmp("R11", 11, 1);
    check("R11 half period 0 as 1", last_hi, 1);
    clk_div = 4'd2;
    read_cmp("R11", 12, 1);
    check("R11 half period 2", last_hi, 2);

    // random mix
    for (int k = 0; k < 12; k++) begin
      s3 = $urandom_range(0, 255);
      s4 = $urandom_range(1, 12);
      for (int i = 0; i < s4; i++) wr_buf[i] = 16'($urandom());
      s0 = n_wren;
      do_write(s3, s4);
      check("R13 random take", op_take, s4);
      check("R8 random error", op_err, 0);
      read_cmp("R7 random", s3, s4);
      read_cmp("R6 random", $urandom_range(0, 255), $urandom_range(1, 16));
    end
    for (int i = 0; i < 256; i++) if (dev_word(i) !== shadow[i]) check("R9 final image", dev_word(i), shadow[i]);

    check("R10 mode 0 phase", phase_viol, 0);
    check("R10 idle pins", {cs_n, sck, mosi}, 3'b101);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule